// File: doc/BRIEF.md
# Byte-Packing Transmit/Receive Word Queue Pair

This block sits between a 32-bit register bus and a byte-serial bus engine. Software writes 32-bit words into a transmit queue. Each word holds up to four bytes, with the least significant byte leaving first. The byte engine pulls those bytes one at a time. In the other direction, the engine delivers received bytes one at a time. The block packs them into 32-bit words, again least significant byte first, and software reads those words from a receive queue. When a transfer ends on a byte count that is not a multiple of four, the final word carries only its low bytes. On transmit, the number of valid bytes is chosen by the register address used for the write. On receive, a last-byte marker from the engine closes the word early.

Software controls the block through one control register. That register holds two self-clearing flush bits and two request threshold fields. A status register reports the number of free transmit slots and the number of filled receive words. Two level outputs ask the software side to refill the transmit queue or to drain the receive queue once the thresholds are met. Two single-cycle event outputs report a write into a full transmit queue and a read from an empty receive queue.

Top module: `pkfifo_pair`

## Requirements
- R1: After reset the control register reads 0 and the status register reads 0x80: eight free transmit slots and no receive words. After reset `tx_byte_valid` is 0, `rx_byte_ready` is 1, `tx_req` is 1 and `rx_req` is 0.
- R2: A transmit word written for four bytes is presented on `tx_byte` as bits 7:0, then 15:8, then 23:16, then 31:24. One byte advances per cycle in which `tx_byte_take` is high while `tx_byte_valid` is high.
- R3: The register address picks the transmit byte count: address 4 sends 1 byte, 5 sends 2, 6 sends 3 and 7 sends 4, always the low bytes of the word. The unused high bytes never appear on `tx_byte`, and the next word follows directly.
- R4: Received bytes are packed little-endian: the first byte lands in bits 7:0 and the fourth in bits 31:24. Each group of four bytes forms one word readable at address 2. A read strobe at address 2 removes that word.
- R5: A byte accepted with `rx_byte_last` high closes the current word at once. The bytes received so far occupy the low lanes, and the next byte starts a new word at lane 0.
- R6: The status register (address 1) holds the free transmit slot count in bits 7:4 and the filled receive word count in bits 3:0. Each field saturates at 15.
- R7: Writing 1 to control bit 1 flushes the transmit queue, and writing 1 to bit 0 flushes the receive queue. The bit reads back 1 in the cycle after the write and 0 from the cycle after that. The flush empties the queue and resets its byte lane position, but keeps both threshold fields unchanged.
- R8: The receive threshold is control bits 4:2 and the transmit threshold is bits 7:5. `tx_req` is high while the free slot count is at least the transmit threshold plus 1. `rx_req` is high while the filled word count is at least the receive threshold plus 1.
- R9: A write to addresses 4–7 while the transmit queue holds 8 words is dropped, and `tx_overflow` pulses high for one cycle in the following cycle.
- R10: A read strobe at address 2 while the receive queue is empty returns 0, leaves the queue unchanged, and pulses `rx_underflow` high for one cycle in the following cycle.
- R11: `rx_byte_ready` is low while the receive queue holds 8 words. A byte offered then is not taken and changes neither the word count nor the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 2) |
| reg_addr | input | 3 | 0 control, 1 status, 2 receive data, 4–7 transmit data of 1–4 bytes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| tx_byte_valid | output | 1 | A transmit byte is available |
| tx_byte | output | 8 | Current transmit byte |
| tx_byte_take | input | 1 | Engine consumes the current transmit byte |
| rx_byte_valid | input | 1 | Engine offers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_byte_last | input | 1 | Offered byte ends the transfer |
| rx_byte_ready | output | 1 | Block can accept a received byte |
| tx_req | output | 1 | Transmit refill request level |
| rx_req | output | 1 | Receive drain request level |
| tx_overflow | output | 1 | One-cycle pulse after a dropped transmit write |
| rx_underflow | output | 1 | One-cycle pulse after a read of an empty receive queue |

## Verification
The byte lanes are checked with distinct values in every lane, so a reversed or shifted lane order gives a wrong byte. Transmit words of two and one valid bytes are followed directly by another word, which shows that the high lanes are skipped rather than sent. A six-byte receive run ending with the last-byte marker shows both a full word and a closed partial word. A flush is issued halfway through a word, and the next word then starts at its first byte, which separates a lane reset from a pointer-only reset. Both queues are filled to capacity to reach the overflow and stall cases, and the threshold fields are set to different values so that swapped fields show up on the request outputs.

// File: rtl/pkfifo_pkg.sv
package pkfifo_pkg;

    localparam int WORD_W      = 32;
    localparam int LANES       = 4;
    localparam int LANE_W      = $clog2(LANES);
    localparam int TRIG_W      = 3;
    localparam int STAT_FLD_W  = 4;

    // Control register bit positions
    localparam int CTL_RXFLUSH   = 0;
    localparam int CTL_TXFLUSH   = 1;
    localparam int CTL_RXTRIG_LO = 2;
    localparam int CTL_TXTRIG_LO = 5;

    typedef logic [7:0]        byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;

    // Register map; transmit aliases carry (byte count - 1) in bits 1:0
    typedef enum logic [2:0] {
        ADR_CTRL = 3'd0,
        ADR_STAT = 3'd1,
        ADR_RXD  = 3'd2,
        ADR_RSV  = 3'd3,
        ADR_TX1  = 3'd4,
        ADR_TX2  = 3'd5,
        ADR_TX3  = 3'd6,
        ADR_TX4  = 3'd7
    } reg_addr_e;

endpackage

// File: rtl/pkfifo_store.sv
module pkfifo_store #(
    parameter int DATA_W = 34,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [OCC_W-1:0]  occupancy
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [OCC_W-1:0] occ;
    } store_st_t;

    store_st_t         st_d, st_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              full_w, empty_w, do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full_w  = (st_q.occ == OCC_W'(DEPTH));
        empty_w = (st_q.occ == '0);
        do_push = push && !full_w && !flush;
        do_pop  = pop && !empty_w && !flush;
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr = bump(st_q.wr);
            if (do_pop)  st_d.rd = bump(st_q.rd);
            case ({do_push, do_pop})
                2'b10:   st_d.occ = st_q.occ + 1'b1;
                2'b01:   st_d.occ = st_q.occ - 1'b1;
                default: st_d.occ = st_q.occ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr] <= din;
    end

    assign dout      = mem_q[st_q.rd];
    assign occupancy = st_q.occ;

    // R9
    occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.occ <= OCC_W'(DEPTH));

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.occ == '0));

    // R10
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty_w && !push && !flush) |=> $stable(st_q.occ));

endmodule

// File: rtl/pkfifo_txun.sv
module pkfifo_txun
    import pkfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  word_valid,
    input  word_t word,
    input  lane_t last_lane,
    input  logic  take,
    output logic  byte_valid,
    output byte_t byte_out,
    output logic  pop
);

    typedef struct packed {
        lane_t lane;
    } unpack_st_t;

    unpack_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        pop        = 1'b0;
        byte_valid = word_valid && !flush;
        byte_out   = word[{st_q.lane, 3'b000} +: 8];
        if (flush) begin
            st_d = '0;
        end else if (take && word_valid) begin
            if (st_q.lane == last_lane) begin
                pop       = 1'b1;
                st_d.lane = '0;
            end else begin
                st_d.lane = st_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    lane_in_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> (st_q.lane <= last_lane));

    // R2
    idle_lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !flush) |=> $stable(st_q.lane));

endmodule

// File: rtl/pkfifo_rxpk.sv
module pkfifo_rxpk
    import pkfifo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  flush,
    input  logic  in_valid,
    input  byte_t in_byte,
    input  logic  in_last,
    input  logic  room,
    output logic  ready,
    output logic  push,
    output word_t word
);

    typedef struct packed {
        lane_t lane;
        word_t acc;
    } pack_st_t;

    pack_st_t st_d, st_q;
    word_t    merged;
    logic     accept;

    always_comb begin
        st_d   = st_q;
        ready  = room && !flush;
        accept = in_valid && ready;
        merged = st_q.acc;
        merged[{st_q.lane, 3'b000} +: 8] = in_byte;
        word   = merged;
        push   = 1'b0;
        if (flush) begin
            st_d = '0;
        end else if (accept) begin
            if (st_q.lane == lane_t'(LANES - 1) || in_last) begin
                push = 1'b1;
                st_d = '0;
            end else begin
                st_d.acc  = merged;
                st_d.lane = st_q.lane + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !room && !flush) |=> $stable(st_q));

    // R5
    fresh_word_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lane == '0) |-> (st_q.acc == '0));

endmodule

// File: rtl/pkfifo_pair.sv
module pkfifo_pair
    import pkfifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_byte_valid,
    output logic [7:0]  tx_byte,
    input  logic        tx_byte_take,
    input  logic        rx_byte_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_byte_last,
    output logic        rx_byte_ready,
    output logic        tx_req,
    output logic        rx_req,
    output logic        tx_overflow,
    output logic        rx_underflow
);

    localparam int OCC_W   = $clog2(DEPTH + 1);
    localparam int TXD_W   = WORD_W + LANE_W;
    localparam int SAT_MAX = (1 << STAT_FLD_W) - 1;

    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;
        logic [TRIG_W-1:0] rx_trig;
        logic              tx_fl;
        logic              rx_fl;
        logic              ovf;
        logic              unf;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic [OCC_W-1:0]      tx_cnt, rx_cnt;
    logic [TXD_W-1:0]      tx_head;
    word_t                 rx_head, rx_word;
    logic                  tx_push, tx_pop, rx_push, rx_pop;
    logic                  tx_full, rx_full, rx_empty;
    logic [31:0]           free_w, fill_w;
    logic [STAT_FLD_W-1:0] stat_tx, stat_rx;

    always_comb begin
        tx_full  = (tx_cnt == OCC_W'(DEPTH));
        rx_full  = (rx_cnt == OCC_W'(DEPTH));
        rx_empty = (rx_cnt == '0);
        tx_push  = reg_wr && reg_addr[2];
        rx_pop   = reg_rd && (reg_addr == ADR_RXD);

        st_d       = st_q;
        st_d.tx_fl = 1'b0;
        st_d.rx_fl = 1'b0;
        st_d.ovf   = tx_push && tx_full && !st_q.tx_fl;
        st_d.unf   = rx_pop && rx_empty && !st_q.rx_fl;
        if (reg_wr && reg_addr == ADR_CTRL) begin
            st_d.tx_trig = reg_wdata[CTL_TXTRIG_LO +: TRIG_W];
            st_d.rx_trig = reg_wdata[CTL_RXTRIG_LO +: TRIG_W];
            st_d.tx_fl   = reg_wdata[CTL_TXFLUSH];
            st_d.rx_fl   = reg_wdata[CTL_RXFLUSH];
        end

        free_w  = 32'(DEPTH) - 32'(tx_cnt);
        fill_w  = 32'(rx_cnt);
        stat_tx = (free_w > 32'(SAT_MAX)) ? STAT_FLD_W'(SAT_MAX) : free_w[STAT_FLD_W-1:0];
        stat_rx = (fill_w > 32'(SAT_MAX)) ? STAT_FLD_W'(SAT_MAX) : fill_w[STAT_FLD_W-1:0];
        tx_req  = free_w >= (32'(st_q.tx_trig) + 32'd1);
        rx_req  = fill_w >= (32'(st_q.rx_trig) + 32'd1);

        case (reg_addr)
            ADR_CTRL: reg_rdata = 32'({st_q.tx_trig, st_q.rx_trig, st_q.tx_fl, st_q.rx_fl});
            ADR_STAT: reg_rdata = 32'({stat_tx, stat_rx});
            ADR_RXD:  reg_rdata = rx_empty ? '0 : rx_head;
            default:  reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_overflow  = st_q.ovf;
    assign rx_underflow = st_q.unf;

    pkfifo_store #(.DATA_W(TXD_W), .DEPTH(DEPTH)) u_tx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (st_q.tx_fl),
        .push      (tx_push),
        .pop       (tx_pop),
        .din       ({reg_addr[1:0], reg_wdata}),
        .dout      (tx_head),
        .occupancy (tx_cnt)
    );

    pkfifo_txun u_txun (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (st_q.tx_fl),
        .word_valid (tx_cnt != '0),
        .word       (tx_head[WORD_W-1:0]),
        .last_lane  (tx_head[TXD_W-1 -: LANE_W]),
        .take       (tx_byte_take),
        .byte_valid (tx_byte_valid),
        .byte_out   (tx_byte),
        .pop        (tx_pop)
    );

    pkfifo_rxpk u_rxpk (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (st_q.rx_fl),
        .in_valid (rx_byte_valid),
        .in_byte  (rx_byte),
        .in_last  (rx_byte_last),
        .room     (!rx_full),
        .ready    (rx_byte_ready),
        .push     (rx_push),
        .word     (rx_word)
    );

    pkfifo_store #(.DATA_W(WORD_W), .DEPTH(DEPTH)) u_rx_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (st_q.rx_fl),
        .push      (rx_push),
        .pop       (rx_pop),
        .din       (rx_word),
        .dout      (rx_head),
        .occupancy (rx_cnt)
    );

    // R7
    txfl_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.tx_fl && !(reg_wr && reg_addr == ADR_CTRL && reg_wdata[CTL_TXFLUSH]))
        |=> !st_q.tx_fl);

    // R7
    trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADR_CTRL) |=> $stable({st_q.tx_trig, st_q.rx_trig}));

    // R9
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && tx_full && !st_q.tx_fl) |=> tx_overflow);

    // R10
    unf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && rx_empty && !st_q.rx_fl) |=> rx_underflow);

    // R11
    ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> !rx_byte_ready);

endmodule

// File: tb/tb_pkfifo_pair.sv
module tb_pkfifo_pair;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        tx_byte_valid;
    logic [7:0]  tx_byte;
    logic        tx_byte_take = 1'b0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_byte_last = 1'b0;
    logic        rx_byte_ready, tx_req, rx_req, tx_overflow, rx_underflow;

    int nvec = 0;
    int nbad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkfifo_pair dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_byte_valid(tx_byte_valid), .tx_byte(tx_byte), .tx_byte_take(tx_byte_take),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_byte_last(rx_byte_last),
        .rx_byte_ready(rx_byte_ready), .tx_req(tx_req), .rx_req(rx_req),
        .tx_overflow(tx_overflow), .rx_underflow(rx_underflow)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_pop(output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = 3'd2;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic push_byte(input logic [7:0] b, input logic last);
        rx_byte_valid = 1'b1; rx_byte = b; rx_byte_last = last;
        @(negedge clk);
        rx_byte_valid = 1'b0; rx_byte_last = 1'b0;
    endtask

    task automatic take_byte(input string tag, input logic [7:0] exp);
        check(tag, {23'd0, tx_byte_valid, tx_byte}, {23'd0, 1'b1, exp});
        tx_byte_take = 1'b1;
        @(negedge clk);
        tx_byte_take = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        peek(3'd0, v); check("R1 ctrl after reset", v, 32'h0);
        peek(3'd1, v); check("R1 status after reset", v, 32'h80);
        check("R1 idle outputs", {27'd0, tx_byte_valid, rx_byte_ready, tx_req, rx_req, tx_overflow},
              {27'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0});
    endtask

    task automatic t_tx_order;
        bus_wr(3'd7, 32'h44332211);
        take_byte("R2 lane0", 8'h11);
        take_byte("R2 lane1", 8'h22);
        take_byte("R2 lane2", 8'h33);
        take_byte("R2 lane3", 8'h44);
        check("R2 drained", {31'd0, tx_byte_valid}, 32'd0);
    endtask

    task automatic t_tx_partial;
        bus_wr(3'd5, 32'hAABBCC01);
        bus_wr(3'd4, 32'hFFFFFF77);
        bus_wr(3'd6, 32'h99654321);
        take_byte("R3 two-byte lane0", 8'h01);
        take_byte("R3 two-byte lane1", 8'hCC);
        take_byte("R3 one-byte", 8'h77);
        take_byte("R3 three-byte lane0", 8'h21);
        take_byte("R3 three-byte lane1", 8'h43);
        take_byte("R3 three-byte lane2", 8'h65);
        check("R3 high lanes skipped", {31'd0, tx_byte_valid}, 32'd0);
    endtask

    task automatic t_rx_pack;
        logic [31:0] v;
        push_byte(8'h10, 1'b0);
        push_byte(8'h20, 1'b0);
        push_byte(8'h30, 1'b0);
        push_byte(8'h40, 1'b0);
        push_byte(8'h50, 1'b0);
        push_byte(8'h60, 1'b1);
        peek(3'd1, v); check("R6 status two rx words", v, 32'h82);
        check("R8 rx_req trig0", {31'd0, rx_req}, 32'd1);
        bus_pop(v); check("R4 full word", v, 32'h40302010);
        bus_pop(v); check("R5 partial low lanes", {16'd0, v[15:0]}, 32'h6050);
        push_byte(8'h71, 1'b0);
        push_byte(8'h72, 1'b0);
        push_byte(8'h73, 1'b0);
        push_byte(8'h74, 1'b0);
        bus_pop(v); check("R5 restart at lane0", v, 32'h74737271);
        peek(3'd1, v); check("R6 status empty", v, 32'h80);
    endtask

    task automatic t_trigger;
        logic [31:0] v;
        bus_wr(3'd0, 32'hA8);
        peek(3'd0, v); check("R8 ctrl fields", v, 32'hA8);
        check("R8 tx_req free8", {31'd0, tx_req}, 32'd1);
        bus_wr(3'd7, 32'h00000051);
        bus_wr(3'd7, 32'h00000052);
        check("R8 tx_req free6", {31'd0, tx_req}, 32'd1);
        bus_wr(3'd7, 32'h00000053);
        check("R8 tx_req free5", {31'd0, tx_req}, 32'd0);
        peek(3'd1, v); check("R6 tx free five", v, 32'h50);
        for (int i = 0; i < 8; i++) push_byte(8'(i), 1'b0);
        check("R8 rx_req two words", {31'd0, rx_req}, 32'd0);
        for (int i = 0; i < 4; i++) push_byte(8'(8 + i), 1'b0);
        check("R8 rx_req three words", {31'd0, rx_req}, 32'd1);
    endtask

    task automatic t_flush;
        logic [31:0] v;
        take_byte("R7 head before flush", 8'h51);
        bus_wr(3'd0, 32'hAA);
        peek(3'd0, v); check("R7 flush pending", v, 32'hAA);
        @(negedge clk);
        peek(3'd0, v); check("R7 flush cleared trig kept", v, 32'hA8);
        peek(3'd1, v); check("R7 tx emptied rx kept", v, 32'h83);
        check("R7 no tx byte", {31'd0, tx_byte_valid}, 32'd0);
        bus_wr(3'd7, 32'h44332211);
        take_byte("R7 lane reset", 8'h11);
        take_byte("R7 lane1", 8'h22);
        take_byte("R7 lane2", 8'h33);
        take_byte("R7 lane3", 8'h44);
        push_byte(8'hE1, 1'b0);
        bus_wr(3'd0, 32'h1);
        @(negedge clk);
        peek(3'd1, v); check("R7 rx flushed", v, 32'h80);
        push_byte(8'hC1, 1'b0);
        push_byte(8'hC2, 1'b1);
        bus_pop(v); check("R7 rx lane reset", {16'd0, v[15:0]}, 32'hC2C1);
        peek(3'd0, v); check("R7 ctrl idle", v, 32'h0);
    endtask

    task automatic t_overflow;
        logic [31:0] v;
        for (int k = 0; k < 8; k++) bus_wr(3'd7, 32'h0A0B0C00 + 32'(k));
        peek(3'd1, v); check("R6 tx full status", v, 32'h00);
        check("R9 no early pulse", {31'd0, tx_overflow}, 32'd0);
        bus_wr(3'd7, 32'hDEADBEEF);
        check("R9 overflow pulse", {31'd0, tx_overflow}, 32'd1);
        @(negedge clk);
        check("R9 pulse single cycle", {31'd0, tx_overflow}, 32'd0);
        peek(3'd1, v); check("R9 still full", v, 32'h00);
        take_byte("R9 head intact", 8'h00);
        bus_wr(3'd0, 32'h2);
        @(negedge clk);
    endtask

    task automatic t_rx_full;
        logic [31:0] v;
        for (int i = 0; i < 32; i++) push_byte(8'(i), 1'b0);
        peek(3'd1, v); check("R11 rx full status", v, 32'h88);
        check("R11 ready low", {31'd0, rx_byte_ready}, 32'd0);
        push_byte(8'hEE, 1'b1);
        peek(3'd1, v); check("R11 stalled byte no effect", v, 32'h88);
        bus_pop(v); check("R11 first word intact", v, 32'h03020100);
        check("R11 ready again", {31'd0, rx_byte_ready}, 32'd1);
        bus_wr(3'd0, 32'h1);
        @(negedge clk);
    endtask

    task automatic t_underflow;
        logic [31:0] v;
        bus_pop(v); check("R10 empty read data", v, 32'h0);
        check("R10 underflow pulse", {31'd0, rx_underflow}, 32'd1);
        @(negedge clk);
        check("R10 pulse single cycle", {31'd0, rx_underflow}, 32'd0);
        peek(3'd1, v); check("R10 queue unchanged", v, 32'h80);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_order();
        t_tx_partial();
        t_rx_pack();
        t_trigger();
        t_flush();
        t_overflow();
        t_rx_full();
        t_underflow();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            nvec++;
            nbad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

endmodule